// File: doc/BRIEF.md
# Three-Channel Tone and Noise Sound Source

This block produces the raw sound source for a three-voice sound generator. A shared divide-by-16 prescaler paces three independent square-wave tone counters and one pseudo-random noise generator. Each voice has a mixer that can admit or block its tone and the shared noise through active-low enable bits. The mixed signal then gates a 4-bit amplitude, and the result is one 4-bit converter code per voice.

The amplitude of each voice comes either from a fixed level that software programs or from an external 4-bit envelope value. A per-voice select bit makes this choice. The inputs are already decoded register fields, held steady by the register file that sits around this block. The outputs are digital codes only. A downstream stage converts each code to a logarithmic analog level.

Top module: `psg_sound_source`

## Requirements
- R1: A shared prescaler produces one pulse every 16 clock cycles. Tone and noise counters advance only on that pulse.
- R2: Each voice's tone output starts low and inverts each time its counter reaches the programmed 12-bit period. That period is measured in prescaler pulses, so one half-wave lasts 16 x period clock cycles. Voice A's period occupies bits 11:0 of `tone_period_i`, voice B's bits 23:12 and voice C's bits 35:24.
- R3: A tone or noise period of 0 behaves exactly like a period of 1.
- R4: Noise comes from a 17-bit shift register that starts at 1. On each noise-period expiry it shifts right by one. The new bit 16 is bit 0 XOR bit 3 of the old value. `noise_bit_o` is bit 0.
- R5: For each voice, the mixer output is (tone OR tone_off) AND (noise OR noise_off). A 1 in an off bit removes that source from the voice. With both sources off, the mixer output is always 1.
- R6: When a voice's `amp_env_sel_i` bit is 1, its amplitude is `env_level_i`. When the bit is 0, its amplitude is its own 4-bit field of `amp_level_i`, using the same per-voice nibble order as `dac_code_o` (voice A in bits 3:0).
- R7: Each voice's `dac_code_o` nibble equals its selected amplitude while its mixer output is 1, and is 0 otherwise. This path is combinational from the current inputs and the current tone and noise state.
- R8: While `rst_n` is low, all counters are cleared, all tone outputs are 0 and the noise register holds 1.
- R9: If a period is lowered below a counter's current count, the counter expires on the next prescaler pulse. It does not wrap through the full count range first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_period_i | input | 36 | Three 12-bit tone periods, voice A lowest |
| noise_period_i | input | 5 | Shared noise period |
| tone_off_i | input | 3 | Active-low tone enables (1 = tone removed), bit 0 = voice A |
| noise_off_i | input | 3 | Active-low noise enables (1 = noise removed), bit 0 = voice A |
| amp_level_i | input | 12 | Three fixed 4-bit levels, voice A lowest |
| amp_env_sel_i | input | 3 | Per-voice select: 1 = envelope level |
| env_level_i | input | 4 | Shared envelope level |
| tone_wave_o | output | 3 | Current square-wave state per voice |
| noise_bit_o | output | 1 | Current noise bit |
| dac_code_o | output | 12 | Three 4-bit converter codes, voice A lowest |

## Verification
The three voices run at distinct periods, including 0 and 1, so that a wrong channel slice or a missing minimum clamp shows up as a wrong toggle interval. The mixer is driven through all four combinations of the enable pairs on different voices. This separates tone gating from noise gating and from the both-off case, which must give a constant code. The envelope value is swept while select bits are mixed, which shows whether each voice takes the right amplitude source. A period drop in the middle of a count tests expiry on the next pulse against a full wrap.

// File: rtl/psg_src_pkg.sv
package psg_src_pkg;
  localparam int LFSR_W    = 17;
  localparam int LFSR_TAP  = 3;
  localparam int PRE_DIV   = 16;

  // one right shift of the noise register, feedback into the top bit
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] cur);
    logic fb;
    fb = cur[0] ^ cur[LFSR_TAP];
    return {fb, cur[LFSR_W-1:1]};
  endfunction

  // active-low source enables: an "off" bit forces that term true
  function automatic logic mix_gate(input logic tone, input logic tone_off,
                                    input logic noise, input logic noise_off);
    return (tone | tone_off) & (noise | noise_off);
  endfunction
endpackage

// File: rtl/psg_prescaler.sv
module psg_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] pre_cnt;

  assign tick_o = (pre_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_cnt <= '0;
    else if (tick_o) pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + 1'b1;
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R1
endmodule

// File: rtl/psg_period_counter.sv
module psg_period_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] period_i,
  output logic         expire_o
);
  logic [W-1:0] cnt;
  logic [W:0]   next_cnt;
  logic [W-1:0] eff_period;

  // zero period is clamped to one
  function automatic logic [W-1:0] clamp_period(input logic [W-1:0] p);
    return (p == '0) ? W'(1) : p;
  endfunction

  assign eff_period = clamp_period(period_i);
  assign next_cnt   = {1'b0, cnt} + 1'b1;
  // ">=" lets a lowered period expire at once instead of wrapping
  assign expire_o   = tick_i && (next_cnt >= {1'b0, eff_period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (expire_o) cnt <= '0;
    else if (tick_i)   cnt <= next_cnt[W-1:0];
  end

  AST_CNT_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt)); // R1
endmodule

// File: rtl/psg_noise_lfsr.sv
module psg_noise_lfsr
  import psg_src_pkg::*;
#(
  parameter int NP_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [NP_W-1:0] period_i,
  output logic            noise_o
);
  logic              step;
  logic [LFSR_W-1:0] lfsr;

  psg_period_counter #(.W(NP_W)) u_ncnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .period_i (period_i),
    .expire_o (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr <= LFSR_W'(1);
    else if (step) lfsr <= lfsr_step(lfsr);
  end

  assign noise_o = lfsr[0];

  AST_LFSR_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R4
  AST_LFSR_HOLDS_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(lfsr)); // R4
  AST_LFSR_STEPS_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> tick_i); // R1
endmodule

// File: rtl/psg_tone_voice.sv
module psg_tone_voice #(
  parameter int TP_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [TP_W-1:0] period_i,
  output logic            tone_o
);
  logic flip;

  psg_period_counter #(.W(TP_W)) u_tcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .period_i (period_i),
    .expire_o (flip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tone_o <= 1'b0;
    else if (flip) tone_o <= ~tone_o;
  end

  AST_TONE_QUIET_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(tone_o)); // R2
  AST_TONE_FLIPS_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (tone_o != $past(tone_o))); // R2
  AST_MIN_PERIOD_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && period_i <= TP_W'(1)) |-> flip); // R3
endmodule

// File: rtl/psg_sound_source.sv
module psg_sound_source
  import psg_src_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int TP_W  = 12,
  parameter int NP_W  = 5,
  parameter int AMP_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*TP_W-1:0]   tone_period_i,
  input  logic [NP_W-1:0]       noise_period_i,
  input  logic [NCH-1:0]        tone_off_i,
  input  logic [NCH-1:0]        noise_off_i,
  input  logic [NCH*AMP_W-1:0]  amp_level_i,
  input  logic [NCH-1:0]        amp_env_sel_i,
  input  logic [AMP_W-1:0]      env_level_i,
  output logic [NCH-1:0]        tone_wave_o,
  output logic                  noise_bit_o,
  output logic [NCH*AMP_W-1:0]  dac_code_o
);
  logic tick;

  psg_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  psg_noise_lfsr #(.NP_W(NP_W)) u_noise (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .period_i (noise_period_i),
    .noise_o  (noise_bit_o)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_voice
    logic             mix;
    logic [AMP_W-1:0] amp;
    logic [AMP_W-1:0] code;

    psg_tone_voice #(.TP_W(TP_W)) u_tone (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .period_i (tone_period_i[ch*TP_W +: TP_W]),
      .tone_o   (tone_wave_o[ch])
    );

    assign mix  = mix_gate(tone_wave_o[ch], tone_off_i[ch], noise_bit_o, noise_off_i[ch]);
    assign amp  = amp_env_sel_i[ch] ? env_level_i : amp_level_i[ch*AMP_W +: AMP_W];
    assign code = mix ? amp : '0;
    assign dac_code_o[ch*AMP_W +: AMP_W] = code;

    AST_TONE_LOW_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      (!tone_off_i[ch] && !tone_wave_o[ch]) |-> (dac_code_o[ch*AMP_W +: AMP_W] == '0)); // R5
    AST_NOISE_LOW_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      (!noise_off_i[ch] && !noise_bit_o) |-> (dac_code_o[ch*AMP_W +: AMP_W] == '0)); // R5
    AST_ENV_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_off_i[ch] && noise_off_i[ch] && amp_env_sel_i[ch])
        |-> (dac_code_o[ch*AMP_W +: AMP_W] == env_level_i)); // R6
    AST_FIXED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_off_i[ch] && noise_off_i[ch] && !amp_env_sel_i[ch])
        |-> (dac_code_o[ch*AMP_W +: AMP_W] == amp_level_i[ch*AMP_W +: AMP_W])); // R7
  end
endmodule

// File: tb/psg_sound_source_test.sv
`timescale 1ns/1ps
module psg_sound_source_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [35:0] tone_period_i = '0;
  logic [4:0]  noise_period_i = '0;
  logic [2:0]  tone_off_i = '0;
  logic [2:0]  noise_off_i = '0;
  logic [11:0] amp_level_i = '0;
  logic [2:0]  amp_env_sel_i = '0;
  logic [3:0]  env_level_i = '0;
  logic [2:0]  tone_wave_o;
  logic        noise_bit_o;
  logic [11:0] dac_code_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk; // 250 MHz

  psg_sound_source uut (
    .clk(clk), .rst_n(rst_n), .tone_period_i(tone_period_i),
    .noise_period_i(noise_period_i), .tone_off_i(tone_off_i),
    .noise_off_i(noise_off_i), .amp_level_i(amp_level_i),
    .amp_env_sel_i(amp_env_sel_i), .env_level_i(env_level_i),
    .tone_wave_o(tone_wave_o), .noise_bit_o(noise_bit_o), .dac_code_o(dac_code_o));

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: integer cycle counting
  int m_clk;          // clocks since reset
  int m_cnt[3];
  int m_tone[3];
  int m_ncnt;
  int m_lfsr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clk = 0; m_ncnt = 0; m_lfsr = 1;
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_tone[i] = 0; end
    end else begin
      if (m_clk % 16 == 15) begin
        for (int i = 0; i < 3; i++) begin
          int p;
          p = tone_period_i[i*12 +: 12];
          if (p == 0) p = 1;
          m_cnt[i]++;
          if (m_cnt[i] >= p) begin m_cnt[i] = 0; m_tone[i] ^= 1; end
        end
        begin
          int np;
          np = noise_period_i;
          if (np == 0) np = 1;
          m_ncnt++;
          if (m_ncnt >= np) begin
            m_ncnt = 0;
            m_lfsr = (m_lfsr >> 1) | (((m_lfsr ^ (m_lfsr >> 3)) & 1) << 16);
          end
        end
      end
      m_clk++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      chk("R2 tone wave A", tone_wave_o[0], m_tone[0]);
      chk("R2 tone wave B", tone_wave_o[1], m_tone[1]);
      chk("R2 tone wave C", tone_wave_o[2], m_tone[2]);
      chk("R4 noise bit", noise_bit_o, m_lfsr & 1);
      for (int i = 0; i < 3; i++) begin
        int mixv, ampv;
        mixv = (m_tone[i] | tone_off_i[i]) & ((m_lfsr & 1) | noise_off_i[i]);
        ampv = amp_env_sel_i[i] ? env_level_i : amp_level_i[i*4 +: 4];
        chk("R7 dac code", dac_code_o[i*4 +: 4], mixv ? ampv : 0);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic drive_edge;
    @(posedge clk); #1;
  endtask

  // clocks between two successive toggles of voice ch
  task automatic half_wave(input int ch, output int len);
    logic v;
    @(negedge clk); v = tone_wave_o[ch];
    while (tone_wave_o[ch] == v) @(negedge clk);
    v = tone_wave_o[ch]; len = 0;
    while (tone_wave_o[ch] == v) begin @(negedge clk); len++; end
  endtask

  initial begin : stim
    int len;
    tone_period_i = {12'd5, 12'd0, 12'd1};
    noise_period_i = 5'd0;
    amp_level_i = {4'd9, 4'd6, 4'd3};
    repeat (3) drive_edge();
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 tone after reset", tone_wave_o, 0);
    chk("R8 noise seed bit", noise_bit_o, 1);
    chk("R8 dac silent", dac_code_o, 0);
    cmp_on = 1;

    // R1: period 1 -> 16 clocks per half wave; R3: period 0 identical
    half_wave(0, len); chk("R1 half wave period 1", len, 16);
    half_wave(1, len); chk("R3 half wave period 0", len, 16);
    half_wave(2, len); chk("R2 half wave period 5", len, 80);

    // R5 mixer combinations
    drive_edge(); tone_off_i = 3'b010; noise_off_i = 3'b100; noise_period_i = 5'd2;
    repeat (400) drive_edge();
    drive_edge(); tone_off_i = 3'b111; noise_off_i = 3'b111;
    repeat (2) @(negedge clk);
    chk("R5 both off voice A", dac_code_o[3:0], 3);
    chk("R5 both off voice C", dac_code_o[11:8], 9);
    drive_edge(); tone_off_i = 3'b000; noise_off_i = 3'b111;
    repeat (300) drive_edge();

    // R6 envelope select with sweeping envelope
    drive_edge(); tone_off_i = 3'b111; amp_env_sel_i = 3'b101;
    for (int e = 0; e < 16; e++) begin
      drive_edge(); env_level_i = 4'(e);
      @(negedge clk);
      chk("R6 env voice A", dac_code_o[3:0], e);
      chk("R6 fixed voice B", dac_code_o[7:4], 6);
    end
    drive_edge(); tone_off_i = 3'b000; noise_off_i = 3'b010; noise_period_i = 5'd31;
    repeat (2000) drive_edge();

    // R9 period lowered mid count
    drive_edge(); tone_period_i[11:0] = 12'd200;
    half_wave(0, len); chk("R2 half wave period 200", len, 3200);
    repeat (16 * 50) @(negedge clk);
    drive_edge(); tone_period_i[11:0] = 12'd2;
    begin
      logic v; int n;
      v = tone_wave_o[0]; n = 0;
      while (tone_wave_o[0] == v && n < 64) begin @(negedge clk); n++; end
      chk("R9 early expiry within one tick", (n >= 1 && n <= 16), 1);
    end
    repeat (1000) drive_edge();

    // R8 reset mid-run
    drive_edge(); rst_n = 0;
    @(negedge clk);
    chk("R8 tone held low in reset", tone_wave_o, 0);
    chk("R8 noise seed in reset", noise_bit_o, 1);
    drive_edge(); rst_n = 1;
    repeat (500) drive_edge();
    finish_run();
  end
endmodule